// File: doc/BRIEF.md
# Byte-Bus Asynchronous Serial Port with Set/Clear Status

This block is an asynchronous serial transmitter and receiver. A host drives it through a byte-wide register bus with registers spaced four bytes apart. The bit rate is set by a 16-bit divisor. A control register selects the frame format (7 or 8 data bits, optional even or odd parity, one or two stop bits), loopback, auto-echo and the two modem outputs. Separate receive and transmit command registers enable each direction and choose how it requests service: none, an interrupt, or one of two DMA request lines.

Both status registers have two addresses. At the read/clear address, writing ones clears the matching bits. At the set address, writing ones forces those bits high, which lets software inject a condition for test. One data address serves both directions: a write loads the transmit holding register, and a read returns the last received byte and clears data ready. The receiver samples each bit at its middle using a 16× oversampling clock. A stop bit sampled low is a framing error. A frame in which every sample is low is a break. A character that arrives while data ready is still set is an overrun, and the buffered byte is kept.

Top module: `sc_uart`

## Requirements
- R1: After reset:
  - line status (offset 0x00) reads 0x06, and the divisor, control and command registers read 0x00;
  - txd, irq and dma_req are all low except txd, which is high.
- R2: The register offsets are:
  - 0x10: divisor high;
  - 0x14: divisor low;
  - 0x18: control;
  - 0x1C: receive command;
  - 0x20: transmit command.
  Each of these reads back the value last written to it.
- R3: Line status bit meanings: 7 data ready, 6 framing error, 5 overrun, 4 parity error, 3 break, 2 holding register empty, 1 shifter empty. Writing ones to offset 0x00 clears the matching bits. Writing ones to offset 0x04 sets them.
- R4: Handshake status (offset 0x08) bit 7 goes high and stays high while dsr is high, and bit 6 does the same for cts. Writing ones to 0x08 clears the matching bits. Writing ones to 0x0C sets them.
- R5: One bit lasts 16 × (divisor + 1) clock cycles, where the divisor is {high, low}.
- R6: Control bits select the frame format:
  - bit 3: 1 = 8 data bits, 0 = 7;
  - bit 2: parity enable;
  - bit 1: odd parity (0 = even);
  - bit 0: two stop bits.
  Data is sent LSB first after a low start bit.
- R7: With receive command bit 7 set, a received frame sets data ready and places the byte at offset 0x24. In 7-bit mode bit 7 of that byte is 0. Reading 0x24 clears data ready.
- R8: A parity mismatch sets bit 4. A low stop bit sets bit 6. All samples low (data, parity and stop) sets bit 3 as well as bit 6.
- R9: A frame that completes while data ready is set sets bit 5 and leaves the buffered byte unchanged.
- R10: Transmit command:
  - bit 7 enables sending;
  - bit 2 holds a loaded character back, with holding-empty low, until it is cleared;
  - bit 1 drives txd low.
  A write to 0x24 clears holding-empty.
- R11: Control bit 6 (loopback) keeps txd high and routes the transmitter output into the receiver.
- R12: Control bit 7 (auto-echo) retransmits every received character. In this mode host writes to 0x24 are ignored.
- R13: Command bits 6:5 select the service request: 00 none, 01 irq, 10 dma_req[0], 11 dma_req[1]. The receive request is data ready and the transmit request is holding-empty. Receive command bit 4 adds an irq when any error bit (6:3) is set.
- R14: dtr follows control bit 5 and rts follows control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on data read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| dsr | input | 1 | Data set ready |
| cts | input | 1 | Clear to send |
| irq | output | 1 | Interrupt request |
| dma_req | output | 2 | DMA requests, channel A in bit 0, channel B in bit 1 |

## Verification
The bench measures a single high data bit on txd, so a design with an off-by-one in the divisor reload would show a pulse one prescale period too long or too short. Error frames are built bit by bit: wrong parity, a low stop bit, and an all-zero break. A receiver that skips the parity sample or reads the stop bit at the wrong position would flag the wrong bits or store a shifted byte. Two back-to-back characters with no read in between check that the first byte survives an overrun, since a design that overwrites the buffer would return the second byte.

The bench also checks three paths where the transmitter should not drive the line:
- With pause set, the line stays high and holding-empty stays low.
- In loopback, txd never falls.
- In auto-echo, a host write would otherwise produce an extra frame; the bench watches txd for one.

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int ADDR_W = 6,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              dtr,
  output logic              rts,
  input  logic              dsr,
  input  logic              cts,
  output logic              irq,
  output logic [1:0]        dma_req
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [ADDR_W-1:0] A_LSC = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_LSS = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_HSC = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_HSS = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_DVH = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_DVL = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_RCM = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_TCM = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(8'h24);

  logic [7:0] lsr, hsr, div_hi, div_lo, ctl, rcmd, tcmd, rbr, thr;
  logic       thr_full;

  wire wr_lsc = bus_wr && bus_addr == A_LSC;
  wire wr_lss = bus_wr && bus_addr == A_LSS;
  wire wr_hsc = bus_wr && bus_addr == A_HSC;
  wire wr_hss = bus_wr && bus_addr == A_HSS;
  wire wr_dat = bus_wr && bus_addr == A_DAT;
  wire rd_dat = bus_rd && bus_addr == A_DAT;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_hi <= '0; div_lo <= '0; ctl <= '0; rcmd <= '0; tcmd <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DVH: div_hi <= bus_wdata;
        A_DVL: div_lo <= bus_wdata;
        A_CTL: ctl    <= bus_wdata;
        A_RCM: rcmd   <= bus_wdata;
        A_TCM: tcmd   <= bus_wdata;
        default: ;
      endcase
    end

  always_comb
    case (bus_addr)
      A_LSC, A_LSS: bus_rdata = lsr;
      A_HSC, A_HSS: bus_rdata = hsr;
      A_DVH:        bus_rdata = div_hi;
      A_DVL:        bus_rdata = div_lo;
      A_CTL:        bus_rdata = ctl;
      A_RCM:        bus_rdata = rcmd;
      A_TCM:        bus_rdata = tcmd;
      A_DAT:        bus_rdata = rbr;
      default:      bus_rdata = '0;
    endcase

  // oversampling prescaler
  logic [15:0] div_cnt;
  wire  [15:0] divisor = {div_hi, div_lo};
  wire         tick    = div_cnt >= divisor;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 16'd1;

  // frame geometry
  wire [3:0] wl      = ctl[3] ? 4'd8 : 4'd7;
  wire [3:0] tx_len  = 4'd2 + wl + {3'b0, ctl[2]} + {3'b0, ctl[0]};
  wire [3:0] rx_stop = 4'd1 + wl + {3'b0, ctl[2]};

  function automatic logic [11:0] build_frame(input logic [7:0] d, input logic [7:0] c);
    logic [11:0] f;
    logic        p;
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || c[3]) f[i+1] = d[i];
    p = (c[3] ? ^d : ^d[6:0]) ^ c[1];
    if (c[2]) f[c[3] ? 9 : 8] = p;
    return f;
  endfunction

  // transmitter
  logic          tx_busy;
  logic [11:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_cnt;
  logic          rx_done;
  logic [7:0]    rx_byte;

  wire host_load = wr_dat && !ctl[7];
  wire echo_load = rx_done && ctl[7];
  wire tx_start  = !tx_busy && thr_full && tcmd[7] && !tcmd[2];
  wire tx_end    = tx_busy && tick && tx_cnt == LAST && tx_left == 4'd1;
  wire tx_line   = tcmd[1] ? 1'b0 : (tx_busy ? tx_sh[0] : 1'b1);

  assign txd = ctl[6] ? 1'b1 : tx_line;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr <= '0; thr_full <= 1'b0;
    end else if (echo_load) begin
      thr <= rx_byte; thr_full <= 1'b1;
    end else if (host_load) begin
      thr <= bus_wdata; thr_full <= 1'b1;
    end else if (tx_start) thr_full <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_cnt <= '0;
    end else if (tx_start) begin
      tx_busy <= 1'b1; tx_sh <= build_frame(thr, ctl); tx_left <= tx_len; tx_cnt <= '0;
    end else if (tx_busy && tick) begin
      tx_cnt <= tx_cnt + 1'b1;
      if (tx_cnt == LAST) begin
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 4'd1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end
    end

  // receiver
  logic [1:0]    rx_sync;
  logic          rx_busy, rx_last, rx_par, rx_zero;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_idx;
  logic [7:0]    rx_sh;

  wire rx_in  = ctl[6] ? tx_line : rx_sync[1];
  wire rx_mid = rx_busy && tick && rx_cnt == MID;
  assign rx_done = rx_mid && rx_idx == rx_stop && rcmd[7];
  assign rx_byte = ctl[3] ? rx_sh : {1'b0, rx_sh[7:1]};

  wire fe_ev  = rx_done && !rx_in;
  wire pe_ev  = rx_done && ctl[2] && (rx_par != ((^rx_byte) ^ ctl[1]));
  wire brk_ev = rx_done && rx_zero && !rx_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_last <= 1'b1; rx_par <= 1'b0; rx_zero <= 1'b0;
      rx_cnt <= '0; rx_idx <= '0; rx_sh <= '0;
    end else if (!rcmd[7]) begin
      rx_busy <= 1'b0; rx_last <= 1'b1;
    end else if (tick) begin
      rx_last <= rx_in;
      if (!rx_busy) begin
        if (rx_last && !rx_in) begin
          rx_busy <= 1'b1; rx_cnt <= '0; rx_idx <= '0; rx_zero <= 1'b1;
        end
      end else begin
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_cnt == MID) begin
          rx_idx <= rx_idx + 4'd1;
          if (rx_idx != 4'd0) rx_zero <= rx_zero & ~rx_in;
          if (rx_idx == 4'd0) begin
            if (rx_in) rx_busy <= 1'b0;
          end else if (rx_idx <= wl) rx_sh <= {rx_in, rx_sh[7:1]};
          else if (rx_idx == rx_stop) rx_busy <= 1'b0;
          else rx_par <= rx_in;
        end
      end
    end

  // line status: software clear, software set, then hardware events
  wire ovr = lsr[7] && !rd_dat;
  logic [7:0] lsr_n;
  always_comb begin
    lsr_n = lsr;
    if (wr_lsc) lsr_n = lsr_n & ~bus_wdata;
    if (wr_lss) lsr_n = lsr_n | bus_wdata;
    if (rd_dat) lsr_n[7] = 1'b0;
    if (tx_start) begin lsr_n[2] = 1'b1; lsr_n[1] = 1'b0; end
    if (host_load || echo_load) lsr_n[2] = 1'b0;
    if (tx_end) lsr_n[1] = 1'b1;
    if (rx_done) begin
      if (ovr) lsr_n[5] = 1'b1;
      else begin
        lsr_n[7] = 1'b1;
        if (fe_ev)  lsr_n[6] = 1'b1;
        if (pe_ev)  lsr_n[4] = 1'b1;
        if (brk_ev) lsr_n[3] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lsr <= 8'h06;
    else        lsr <= lsr_n & 8'hFE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 rbr <= '0;
    else if (rx_done && !ovr)   rbr <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hsr <= '0;
    else hsr <= ((((hsr & ~(wr_hsc ? bus_wdata : 8'h00)) | (wr_hss ? bus_wdata : 8'h00))
                 | {dsr, cts, 6'b0}) & 8'hC0);

  // service requests
  wire rx_req = rcmd[7] && lsr[7];
  wire tx_req = tcmd[7] && lsr[2];
  wire err    = |lsr[6:3];

  assign irq = (rcmd[6:5] == 2'b01 && rx_req) || (tcmd[6:5] == 2'b01 && tx_req) ||
               (tcmd[4] && tcmd[7] && lsr[1]) || ((rcmd[4] || tcmd[3]) && err);
  assign dma_req[0] = (rcmd[6:5] == 2'b10 && rx_req) || (tcmd[6:5] == 2'b10 && tx_req);
  assign dma_req[1] = (rcmd[6:5] == 2'b11 && rx_req) || (tcmd[6:5] == 2'b11 && tx_req);
  assign dtr = ctl[5];
  assign rts = ctl[4];

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lsc && bus_wdata[6] && !wr_lss && !rx_done) |=> !lsr[6]); // R3
  AST_SET_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lss && bus_wdata[3]) |=> lsr[3]); // R3
  AST_READ_CLEARS_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && !rx_done && !(wr_lss && bus_wdata[7])) |=> !lsr[7]); // R7
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && lsr[7] && !rd_dat) |=> (lsr[5] && $stable(rbr))); // R9
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tcmd[2] && !tx_busy) |=> !tx_busy); // R10
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tcmd[1] && !ctl[6]) |-> !txd); // R10
  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[6] |-> txd); // R11
  AST_ECHO_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[7] && wr_dat && !rx_done) |=> $stable(thr)); // R12
endmodule

// File: tb/sc_uart_tb.sv
module sc_uart_tb_top;
  logic clk = 0, rst_n = 0;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic rxd = 1, dsr = 0, cts = 0;
  logic txd, dtr, rts, irq;
  logic [1:0] dma_req;
  int checks = 0, errors = 0, bitclk = 16;

  always #10 clk = ~clk;

  sc_uart dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .dtr(dtr), .rts(rts),
    .dsr(dsr), .cts(cts), .irq(irq), .dma_req(dma_req));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  function automatic bit par(input logic [7:0] d, input logic [3:0] f);
    return (f[3] ? ^d : ^d[6:0]) ^ f[1];
  endfunction

  task automatic set_div(input int dv);
    wr(6'h10, 8'(dv >> 8)); wr(6'h14, 8'(dv)); bitclk = 16 * (dv + 1);
  endtask

  task automatic hold_bit(input logic v);
    rxd = v; repeat (bitclk) @(negedge clk);
  endtask

  // f: {8bit, par_en, odd, two_stop}
  task automatic send(input logic [7:0] d, input logic [3:0] f, input bit bad_par, input logic stop);
    @(negedge clk);
    hold_bit(1'b0);
    for (int i = 0; i < (f[3] ? 8 : 7); i++) hold_bit(d[i]);
    if (f[2]) hold_bit(par(d, f) ^ bad_par);
    hold_bit(stop);
    if (f[0]) hold_bit(1'b1);
    rxd = 1'b1;
    repeat (bitclk + 4) @(negedge clk);
  endtask

  task automatic recv(input logic [3:0] f, output logic [7:0] d, output bit ok);
    int t = 0;
    d = '0; ok = 1;
    while (txd !== 1'b0 && t < 40 * bitclk) begin @(negedge clk); t++; end
    if (t >= 40 * bitclk) begin ok = 0; return; end
    repeat (bitclk / 2) @(negedge clk);
    if (txd !== 1'b0) ok = 0;
    for (int i = 0; i < (f[3] ? 8 : 7); i++) begin
      repeat (bitclk) @(negedge clk); d[i] = txd;
    end
    if (f[2]) begin repeat (bitclk) @(negedge clk); if (txd !== par(d, f)) ok = 0; end
    for (int i = 0; i < (f[0] ? 2 : 1); i++) begin
      repeat (bitclk) @(negedge clk); if (txd !== 1'b1) ok = 0;
    end
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic watch_high(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
  endtask

  task automatic run();
    logic [7:0] v, d, exp;
    logic [3:0] f;
    bit ok;
    int lows, len;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk); rst_n = 1;
    // R1
    rd(6'h00, v); check(v == 8'h06, "R1 lsr reset", v, 8'h06);
    rd(6'h18, v); check(v == 8'h00, "R1 ctl reset", v, 0);
    check(txd === 1'b1 && irq === 1'b0 && dma_req === 2'b00, "R1 outputs", {txd, irq, dma_req}, 4'b1000);
    // R2
    wr(6'h10, 8'h12); wr(6'h14, 8'h34); wr(6'h1C, 8'h5A); wr(6'h20, 8'h21);
    rd(6'h10, v); check(v == 8'h12, "R2 div hi", v, 8'h12);
    rd(6'h14, v); check(v == 8'h34, "R2 div lo", v, 8'h34);
    rd(6'h1C, v); check(v == 8'h5A, "R2 rcmd", v, 8'h5A);
    rd(6'h20, v); check(v == 8'h21, "R2 tcmd", v, 8'h21);
    wr(6'h1C, 8'h00); wr(6'h20, 8'h00);
    // R14
    wr(6'h18, 8'h30); #1 check(dtr && rts, "R14 both", {dtr, rts}, 2'b11);
    wr(6'h18, 8'h20); #1 check(dtr && !rts, "R14 dtr only", {dtr, rts}, 2'b10);
    // R3
    wr(6'h04, 8'h78); rd(6'h00, v); check(v == 8'h7E, "R3 set", v, 8'h7E);
    wr(6'h00, 8'h50); rd(6'h00, v); check(v == 8'h2E, "R3 clear", v, 8'h2E);
    wr(6'h00, 8'hFF); wr(6'h04, 8'h06); rd(6'h00, v); check(v == 8'h06, "R3 restore", v, 8'h06);
    // R4
    dsr = 1; @(negedge clk); dsr = 0;
    rd(6'h08, v); check(v == 8'h80, "R4 dsr sticky", v, 8'h80);
    wr(6'h08, 8'h80); rd(6'h08, v); check(v == 8'h00, "R4 clear", v, 0);
    wr(6'h0C, 8'h40); rd(6'h0C, v); check(v == 8'h40, "R4 set", v, 8'h40);
    cts = 1; wr(6'h08, 8'hFF); rd(6'h08, v); check(v == 8'h40, "R4 cts holds", v, 8'h40);
    cts = 0; wr(6'h08, 8'hFF);
    // R5: second data bit high alone, 8N1, divisor 2
    set_div(2); wr(6'h18, 8'h08); wr(6'h20, 8'h80); wr(6'h24, 8'h02);
    while (txd !== 1'b0) @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
    len = 0; while (txd === 1'b1) begin @(negedge clk); len++; end
    check(len == 48, "R5 bit length", len, 48);
    repeat (12 * bitclk) @(negedge clk);
    // R6 R7 random frames both directions
    wr(6'h1C, 8'h80);
    for (int it = 0; it < 14; it++) begin
      set_div($urandom_range(0, 3));
      f = 4'($urandom); d = 8'($urandom);
      wr(6'h18, {4'b0000, f});
      exp = f[3] ? d : {1'b0, d[6:0]};
      send(d, f, 0, 1'b1);
      rd(6'h00, v); check((v & 8'hF8) == 8'h80, "R7 rx status", v, 8'h80);
      rd(6'h24, v); check(v == exp, "R7 rx data", v, exp);
      rd(6'h00, v); check(v[7] == 1'b0, "R7 read clears ready", v, 0);
      d = 8'($urandom); exp = f[3] ? d : {1'b0, d[6:0]};
      wr(6'h24, d); recv(f, v, ok);
      check(ok && v == exp, "R6 tx frame", v, exp);
    end
    // R8
    set_div(1); wr(6'h18, 8'h0C);
    send(8'h3C, 4'hC, 1, 1'b1); rd(6'h00, v); check((v & 8'hF8) == 8'h90, "R8 parity", v, 8'h90);
    rd(6'h24, v); wr(6'h00, 8'h78);
    send(8'hA5, 4'hC, 0, 1'b0); rd(6'h00, v); check((v & 8'hF8) == 8'hC0, "R8 framing", v, 8'hC0);
    rd(6'h24, v); wr(6'h00, 8'h78);
    send(8'h00, 4'hC, 0, 1'b0); rd(6'h00, v); check((v & 8'hF8) == 8'hC8, "R8 break", v, 8'hC8);
    rd(6'h24, v); wr(6'h00, 8'h78);
    // R9
    wr(6'h18, 8'h08);
    send(8'h11, 4'h8, 0, 1'b1); send(8'h22, 4'h8, 0, 1'b1);
    rd(6'h00, v); check((v & 8'hF8) == 8'hA0, "R9 overrun flag", v, 8'hA0);
    rd(6'h24, v); check(v == 8'h11, "R9 first byte kept", v, 8'h11);
    wr(6'h00, 8'h78);
    // R10 pause and break
    wr(6'h20, 8'h84); wr(6'h24, 8'h6B);
    watch_high(12 * bitclk, lows); check(lows == 0, "R10 pause holds line", lows, 0);
    rd(6'h00, v); check(v[2] == 1'b0, "R10 holding not empty", v, 8'h00);
    wr(6'h20, 8'h80); recv(4'h8, v, ok); check(ok && v == 8'h6B, "R10 release", v, 8'h6B);
    wr(6'h20, 8'h82); @(negedge clk); check(txd === 1'b0, "R10 break low", txd, 0);
    wr(6'h20, 8'h80); @(negedge clk); check(txd === 1'b1, "R10 break off", txd, 1);
    // R11 loopback
    wr(6'h18, 8'h48); wr(6'h24, 8'h3C);
    watch_high(14 * bitclk, lows); check(lows == 0, "R11 line idle", lows, 0);
    rd(6'h24, v); check(v == 8'h3C, "R11 looped byte", v, 8'h3C);
    // R12 auto-echo
    wr(6'h18, 8'h88);
    fork
      send(8'h5A, 4'h8, 0, 1'b1);
      begin recv(4'h8, v, ok); check(ok && v == 8'h5A, "R12 echo", v, 8'h5A); end
    join
    rd(6'h24, v);
    repeat (4 * bitclk) @(negedge clk);
    wr(6'h24, 8'h77); watch_high(14 * bitclk, lows); check(lows == 0, "R12 host write ignored", lows, 0);
    rd(6'h00, v); check(v[2] == 1'b1, "R12 holding still empty", v, 8'h04);
    // R13
    wr(6'h18, 8'h08); wr(6'h00, 8'h78); wr(6'h20, 8'h00);
    wr(6'h1C, 8'hA0); send(8'h44, 4'h8, 0, 1'b1);
    check(irq === 1'b1 && dma_req === 2'b00, "R13 irq mode", {irq, dma_req}, 3'b100);
    rd(6'h24, v); #1 check(irq === 1'b0, "R13 irq drops", irq, 0);
    wr(6'h1C, 8'hC0); send(8'h45, 4'h8, 0, 1'b1);
    check(dma_req === 2'b01 && !irq, "R13 dma A", dma_req, 1);
    rd(6'h24, v); wr(6'h1C, 8'hE0); send(8'h46, 4'h8, 0, 1'b1);
    check(dma_req === 2'b10 && !irq, "R13 dma B", dma_req, 2);
    rd(6'h24, v); wr(6'h1C, 8'h90); wr(6'h04, 8'h20); #1
    check(irq === 1'b1, "R13 error irq", irq, 1);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule